// File: doc/BRIEF.md
# Hopping PWM Generator with Wrap-Aligned Reload

The block produces a pulse-width-modulated output from a 16-bit up-counter and steps through a fixed list of (period, duty) settings. A frame starts with the counter at 0 and the output high. The output drops when the count reaches the duty value. The counter returns to 0 on the cycle after it has matched the period value. The settings list is fixed at build time through parameters. The default list has seven entries: (132,66), (131,66), (130,65), (129,65), (128,64), (127,64), (126,63).

A single-cycle pulse on the hop input moves the list index on by one and raises a pending flag. The new period and duty are not applied at once. They are copied into the live registers only at the next counter wrap, and the pending flag clears at that point. Each new setting therefore starts a fresh frame at count 0. A period below the running count can never be installed, so the counter never runs on to its 16-bit limit and the output never drops out for a full roll-over. The output always stays in PWM operation and never falls back to an idle level during an update.

Top module: `hop_pwm`

## Requirements
- R1: During reset and out of it, the index is 0 and entry 0 is loaded. `pwm_o` is high and `wrap_o` is low while reset is held. The first frame after release is (period 0)+1 cycles long and `pwm_o` is high for (duty 0) of those cycles.
- R2: While enabled, each frame lasts period+1 cycles (counts 0 through period). `wrap_o` is high for exactly one cycle, the cycle in which the count is 0 again.
- R3: Within a frame, `pwm_o` is high for counts below the duty value and low from the duty value up to the period. It is therefore high for exactly `duty` cycles of each frame.
- R4: A hop request moves the index to (index+1) mod N_ENT, wrapping from the last entry to entry 0, and sets the pending flag. The frame in progress keeps its settings. The frame that starts at the next wrap uses the new entry.
- R5: A wrap with no pending update leaves the period and duty unchanged, so consecutive frames stay identical.
- R6: If several hop requests arrive before a wrap, the index advances once for each request. Only the latest entry is loaded at that wrap.
- R7: A hop request sampled on the same edge as a wrap does not take part in that wrap's reload. If an update was already pending, that wrap loads the index held before the request. The request stays pending and is applied at the following wrap.
- R8: While `en_i` is low, the counter, `pwm_o` and the live settings are frozen and `wrap_o` stays low. Hop requests are still recorded and are applied at the first wrap after the block is enabled again.
- R9: The count never exceeds the live period, so no frame is longer than the largest table period plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Count enable; low freezes the generator |
| hop_i | input | 1 | One-cycle request to step to the next table entry |
| pwm_o | output | 1 | Registered PWM output |
| wrap_o | output | 1 | One-cycle strobe, high in the cycle the count is 0 again |

## Verification
`pwm_o` and `wrap_o` are both registered. A frame therefore begins in the cycle that `wrap_o` is high, and the output is high in that same cycle. The bench samples on the falling edge and counts enabled cycles and high cycles from one `wrap_o` sample to the next. This gives period+1 and duty for each frame. A hop driven at the falling edge after the cycle for count L is sampled on the rising edge where the count is L. Its effect is expected in the frame that starts at the next wrap. A hop at count equal to the period falls on the wrap edge itself, and the bench expects the reload to be deferred to the wrap after that.

// File: rtl/hop_pwm_pkg.sv
package hop_pwm_pkg;
  localparam int unsigned CNT_W = 16;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t period;
    cnt_t duty;
  } frame_cfg_t;
endpackage

// File: rtl/hop_tbl.sv
module hop_tbl import hop_pwm_pkg::*; #(
  parameter int unsigned N_ENT = 7,
  parameter int unsigned IDX_W = 3,
  parameter logic [N_ENT*CNT_W-1:0] PER_TBL  = '0,
  parameter logic [N_ENT*CNT_W-1:0] DUTY_TBL = '0
) (
  input  logic [IDX_W-1:0] idx_i,
  output frame_cfg_t       cfg_o
);
  frame_cfg_t rows [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_row
    assign rows[g] = '{period: PER_TBL[g*CNT_W +: CNT_W],
                       duty:   DUTY_TBL[g*CNT_W +: CNT_W]};
  end

  always_comb begin
    cfg_o = rows[0];
    for (int i = 0; i < N_ENT; i++) begin
      if (idx_i == IDX_W'(i)) cfg_o = rows[i];
    end
  end
endmodule

// File: rtl/hop_seq.sv
module hop_seq #(
  parameter int unsigned N_ENT = 7,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hop_i,
  input  logic             roll_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             load_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

  logic [IDX_W-1:0] idx_q;
  logic             pend_q;

  // reload only at a roll, and only with a request already registered
  assign load_o = roll_i & pend_q;
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (hop_i) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
      if (hop_i)       pend_q <= 1'b1;
      else if (load_o) pend_q <= 1'b0;
    end
  end

  a_r4_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST);
  a_r5_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hop_i |=> $stable(idx_q));
  a_r6_pend_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hop_i |=> pend_q);
  a_r4_pend_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o && !hop_i |=> !pend_q);
endmodule

// File: rtl/pwm_core.sv
module pwm_core import hop_pwm_pkg::*; #(
  parameter frame_cfg_t CFG0 = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       load_i,
  input  frame_cfg_t nxt_cfg_i,
  output logic       roll_o,
  output logic       wrap_o,
  output logic       pwm_o
);
  cnt_t       cnt_q, cnt_d;
  frame_cfg_t cfg_q, cfg_d;
  logic       wrap_q, pwm_q, pwm_d;

  assign roll_o = en_i & (cnt_q == cfg_q.period);

  always_comb begin
    cnt_d = cnt_q;
    cfg_d = cfg_q;
    if (en_i)   cnt_d = roll_o ? '0 : cnt_q + 1'b1;
    if (load_i) cfg_d = nxt_cfg_i;
    pwm_d = (cnt_d < cfg_d.duty);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cfg_q  <= CFG0;
      wrap_q <= 1'b0;
      pwm_q  <= (CFG0.duty != '0);
    end else begin
      cnt_q  <= cnt_d;
      cfg_q  <= cfg_d;
      wrap_q <= roll_o;
      pwm_q  <= pwm_d;
    end
  end

  assign wrap_o = wrap_q;
  assign pwm_o  = pwm_q;

  a_r9_cnt_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= cfg_q.period);
  a_r2_wrap_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o && (cfg_q.period != '0) |=> !wrap_o);
  a_r5_cfg_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> wrap_o);
  a_r3_high_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o && (cfg_q.duty != '0) |-> pwm_o);
  a_r8_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q) && $stable(pwm_q) && !wrap_o);
endmodule

// File: rtl/hop_pwm.sv
module hop_pwm import hop_pwm_pkg::*; #(
  parameter int unsigned N_ENT = 7,
  parameter logic [N_ENT*CNT_W-1:0] PER_TBL =
    {16'd126, 16'd127, 16'd128, 16'd129, 16'd130, 16'd131, 16'd132},
  parameter logic [N_ENT*CNT_W-1:0] DUTY_TBL =
    {16'd63, 16'd64, 16'd64, 16'd65, 16'd65, 16'd66, 16'd66}
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hop_i,
  output logic pwm_o,
  output logic wrap_o
);
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam frame_cfg_t  CFG0  = '{period: PER_TBL[CNT_W-1:0],
                                    duty:   DUTY_TBL[CNT_W-1:0]};

  logic [IDX_W-1:0] idx;
  logic             roll, load;
  frame_cfg_t       nxt_cfg;

  hop_seq #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hop_i  (hop_i),
    .roll_i (roll),
    .idx_o  (idx),
    .load_o (load)
  );

  hop_tbl #(.N_ENT(N_ENT), .IDX_W(IDX_W),
            .PER_TBL(PER_TBL), .DUTY_TBL(DUTY_TBL)) u_tbl (
    .idx_i (idx),
    .cfg_o (nxt_cfg)
  );

  pwm_core #(.CFG0(CFG0)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .load_i    (load),
    .nxt_cfg_i (nxt_cfg),
    .roll_o    (roll),
    .wrap_o    (wrap_o),
    .pwm_o     (pwm_o)
  );
endmodule

// File: tb/hop_pwm_tb_top.sv
module hop_pwm_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b1;
  logic hop_i = 1'b0;
  logic pwm_o, wrap_o;
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  always #4 clk_i = ~clk_i;

  hop_pwm dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .hop_i  (hop_i),
    .pwm_o  (pwm_o),
    .wrap_o (wrap_o)
  );

  function automatic int exp_per(int e);
    return 132 - e;
  endfunction

  function automatic int exp_duty(int e);
    return 66 - e / 2;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // starts and ends at a falling edge where wrap_o is high
  task automatic run_frame(input int hop_a, input int hop_b, input int gap_at,
                           input bit gap_hop, input int e, input string req);
    int   len;
    int   high;
    logic v;
    len  = 0;
    high = 0;
    do begin
      len++;
      if (pwm_o) high++;
      hop_i = (len == hop_a) || (len == hop_b);
      if (len == gap_at) begin
        en_i = 1'b0;
        v    = pwm_o;
        for (int k = 0; k < 20; k++) begin
          @(negedge clk_i);
          hop_i = gap_hop && (k == 5);
          chk(pwm_o == v && !wrap_o, "R8", "frozen output", int'(pwm_o), int'(v));
        end
        hop_i = 1'b0;
        en_i  = 1'b1;
      end
      @(negedge clk_i);
    end while (!wrap_o && len < 70000);
    hop_i = 1'b0;
    chk(len == exp_per(e) + 1, "R2", {req, " frame length"}, len, exp_per(e) + 1);
    chk(high == exp_duty(e), "R3", {req, " high cycles"}, high, exp_duty(e));
    chk(len <= 133, "R9", {req, " no dropout"}, len, 133);
  endtask

  initial begin
    #(8 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL R9 watchdog expired");
    finish_run();
  end

  initial begin
    int len;
    int high;
    repeat (3) @(negedge clk_i);
    chk(pwm_o == 1'b1, "R1", "pwm in reset", int'(pwm_o), 1);
    chk(wrap_o == 1'b0, "R1", "wrap in reset", int'(wrap_o), 0);
    rst_ni = 1'b1;
    len  = 0;
    high = 0;
    do begin
      len++;
      if (pwm_o) high++;
      @(negedge clk_i);
    end while (!wrap_o && len < 70000);
    chk(len == 133, "R1", "first frame length", len, 133);
    chk(high == 66, "R1", "first frame high", high, 66);

    run_frame(0, 0, 0, 0, 0, "R5 steady");
    // R4: sweep every entry and wrap back past the last one
    for (int k = 1; k <= 8; k++) run_frame(10, 0, 0, 0, (k - 1) % 7, "R4 sweep");
    run_frame(0, 0, 0, 0, 1, "R4 after sweep");
    run_frame(0, 0, 0, 0, 1, "R5 hold");
    // R6: two hops in one frame
    run_frame(5, 40, 0, 0, 1, "R6 double hop");
    run_frame(0, 0, 0, 0, 3, "R6 latest entry");
    // R7: hop on the wrap edge with nothing pending
    run_frame(130, 0, 0, 0, 3, "R7 hop at top");
    run_frame(0, 0, 0, 0, 3, "R7 deferred");
    run_frame(0, 0, 0, 0, 4, "R7 applied");
    // R7: hop on the wrap edge while an update is pending
    run_frame(5, 129, 0, 0, 4, "R7 pending plus top");
    run_frame(0, 0, 0, 0, 5, "R7 old index");
    run_frame(0, 0, 0, 0, 6, "R7 late request");
    run_frame(0, 0, 0, 0, 6, "R5 hold late");
    // R8: freeze with a hop recorded during the gap
    run_frame(0, 0, 30, 1, 6, "R8 gap");
    run_frame(0, 0, 0, 0, 0, "R8 hop in gap");
    finish_run();
  end
endmodule